// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog counter that advances on tick enables from its own free-running oscillator. Because of that, it keeps counting while the main device clock is stopped, for example in sleep. One 8-bit prescaler is shared with a general-purpose timer. A routing bit in an option register places the prescaler either behind the watchdog, as a postscaler, or in front of the timer input. A 3-bit tap field picks one of eight division ratios.

When the watchdog expires during normal operation, the block emits a one-cycle device-reset pulse. When it expires during sleep, it emits a one-cycle wake-up pulse instead. In both cases an active-low time-out status flag drops. Software keeps the watchdog from expiring with a clear strobe or a sleep strobe. Both strobes restart the count. Neither strobe changes the routing bit or the tap field.

All inputs are synchronous to `clk`. The oscillator tick and the timer source arrive as single-cycle enables.

Top module: `wdt_shared_prescaler`

## Requirements
- R1: After power-on reset the outputs are as follows: `to_n_o`=1, `rst_pulse_o`=0, `wake_pulse_o`=0, `tmr_tick_o`=0. The option register reads all ones, so bit 3 (routing)=1 and bits 2:0 (tap)=7. The first time-out therefore comes after 256*128 counted oscillator ticks.
- R2: When the watchdog is enabled, the 8-bit base counter advances on each `osc_tick_i` and overflows every 256 ticks. With option bit 3 = 0, each overflow is a time-out.
- R3: A time-out while `in_sleep_i`=0 gives exactly one cycle of `rst_pulse_o`. The pulse appears in the cycle after the clock edge that took the completing tick.
- R4: A time-out while `in_sleep_i`=1 gives one cycle of `wake_pulse_o` instead, and no reset pulse.
- R5: `to_n_o` falls to 0 in the same cycle as the reset or wake pulse of a time-out, and it falls at no other time.
- R6: While `cfg_wd_en_i`=0 the base counter is held at zero and no time-out occurs.
- R7: `clr_wd_i` zeroes the base counter. It zeroes the prescaler count only when option bit 3 = 1. It sets `to_n_o` to 1 on the next cycle. It leaves the option fields unchanged.
- R8: `sleep_i` zeroes the base counter, and also the prescaler count when bit 3 = 1. It does not change `to_n_o`.
- R9: With option bit 3 = 1, `tmr_tick_o` repeats `tmr_src_i` one cycle later. A time-out occurs once per 2^PS base overflows, where PS = bits 2:0.
- R10: With option bit 3 = 0, `tmr_tick_o` pulses once per 2^(PS+1) source events, and a clear strobe does not disturb that count.
- R11: A write (`opt_we_i`) loads the option register from `opt_d_i` and restarts the prescaler count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_tick_i | input | 1 | Watchdog oscillator tick enable |
| tmr_src_i | input | 1 | Timer clock source event |
| cfg_wd_en_i | input | 1 | Configuration enable of the watchdog |
| opt_we_i | input | 1 | Option register write strobe |
| opt_d_i | input | 8 | Option write data: bit 3 routing, bits 2:0 tap |
| clr_wd_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| in_sleep_i | input | 1 | Device is in sleep mode |
| rst_pulse_o | output | 1 | One-cycle device reset request |
| wake_pulse_o | output | 1 | One-cycle wake-up request |
| to_n_o | output | 1 | Time-out status, 0 after a time-out |
| tmr_tick_o | output | 1 | Prescaled (or raw) timer tick |

## Verification
A base or prescaler count that is off by even one shows up directly at the ports. The reset or wake pulse moves by at least one oscillator tick, and the bench's cycle model flags that pulse in its first wrong cycle. A prescaler count that a strobe or option write fails to restart is different: it stays hidden until the next tap hit, which comes up to 2^(PS+1) events later. For that reason the directed windows are sized so that a missed restart changes the number of pulses inside the window. A wrong routing bit shows at once on `tmr_tick_o`, which then carries the raw source instead of the divided one, or the reverse.

// File: rtl/wdt_sp_pkg.sv
package wdt_sp_pkg;

   // Routing of the shared prescaler (value of the option routing bit)
   typedef enum logic {
      ROUTE_TIMER    = 1'b0,
      ROUTE_WATCHDOG = 1'b1
   } route_e;

   // Number of selectable taps for a given select width
   function automatic int unsigned tap_count(input int unsigned sel_w);
      return 32'd1 << sel_w;
   endfunction

endpackage

// File: rtl/wdt_sp_base_cnt.sv
module wdt_sp_base_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   input  logic clr_i,
   output logic ovf_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("wdt_sp_base_cnt: CNT_W must be at least 2");
      end
   endgenerate

   // Overflow when the all-ones count takes one more tick
   assign ovf_o = en_i & tick_i & ~clr_i & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || !en_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

endmodule

// File: rtl/wdt_sp_prescaler.sv
module wdt_sp_prescaler
   import wdt_sp_pkg::*;
#(
   parameter int unsigned PRE_W = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             clr_i,
   input  route_e           route_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             hit_o
);
   localparam int unsigned NTAP = tap_count(SEL_W);
   localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  post_tap;   // watchdog side: 2^k
   logic [NTAP-1:0]  tmr_tap;    // timer side: 2^(k+1)
   logic             tap_sel;

   generate
      if (NTAP > PRE_W) begin : g_bad_taps
         $error("wdt_sp_prescaler: 2**SEL_W taps exceed PRE_W bits");
      end
      for (genvar k = 0; k < NTAP; k++) begin : g_tap
         if (k == 0) begin : g_first
            assign post_tap[k] = 1'b1;
         end else begin : g_rest
            assign post_tap[k] = &pre_q[k-1:0];
         end
         assign tmr_tap[k] = &pre_q[k:0];
      end
   endgenerate

   assign tap_sel = (route_i == ROUTE_WATCHDOG) ? post_tap[sel_i] : tmr_tap[sel_i];
   assign hit_o   = evt_i & ~clr_i & tap_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clr_i) begin
         pre_q <= '0;
      end else if (evt_i) begin
         pre_q <= pre_q + PRE_ONE;
      end
   end

endmodule

// File: rtl/wdt_sp_event_out.sv
module wdt_sp_event_out (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout_i,
   input  logic in_sleep_i,
   input  logic clr_wd_i,
   input  logic tmr_tick_i,
   output logic rst_pulse_o,
   output logic wake_pulse_o,
   output logic to_n_o,
   output logic tmr_tick_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pulse_o  <= 1'b0;
         wake_pulse_o <= 1'b0;
         tmr_tick_o   <= 1'b0;
         to_n_o       <= 1'b1;
      end else begin
         rst_pulse_o  <= timeout_i & ~in_sleep_i;
         wake_pulse_o <= timeout_i & in_sleep_i;
         tmr_tick_o   <= tmr_tick_i;
         if (clr_wd_i) begin
            to_n_o <= 1'b1;
         end else if (timeout_i) begin
            to_n_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wdt_shared_prescaler.sv
module wdt_shared_prescaler
   import wdt_sp_pkg::*;
#(
   parameter int unsigned BASE_W    = 8,
   parameter int unsigned PRE_W     = 8,
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned OPT_W     = 8,
   parameter int unsigned ROUTE_BIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick_i,
   input  logic             tmr_src_i,
   input  logic             cfg_wd_en_i,
   input  logic             opt_we_i,
   input  logic [OPT_W-1:0] opt_d_i,
   input  logic             clr_wd_i,
   input  logic             sleep_i,
   input  logic             in_sleep_i,
   output logic             rst_pulse_o,
   output logic             wake_pulse_o,
   output logic             to_n_o,
   output logic             tmr_tick_o
);
   localparam int unsigned KEEP_W = ROUTE_BIT + 1;

   generate
      if (ROUTE_BIT < SEL_W) begin : g_bad_route
         $error("wdt_shared_prescaler: routing bit overlaps the tap field");
      end
      if (KEEP_W > OPT_W) begin : g_bad_opt
         $error("wdt_shared_prescaler: routing bit outside the option word");
      end
   endgenerate

   route_e           route_q;
   logic [SEL_W-1:0] sel_q;
   logic             unused_opt_bits;
   logic             wd_clr;
   logic             base_ovf;
   logic             pre_evt;
   logic             pre_clr;
   logic             pre_hit;
   logic             timeout;
   logic             tick_next;

   // Option register: only the routing bit and tap field are decoded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= ROUTE_WATCHDOG;
         sel_q   <= '1;
      end else if (opt_we_i) begin
         route_q <= route_e'(opt_d_i[ROUTE_BIT]);
         sel_q   <= opt_d_i[SEL_W-1:0];
      end
   end

   generate
      if (KEEP_W < OPT_W) begin : g_hi
         assign unused_opt_bits = &{1'b0, opt_d_i[OPT_W-1:KEEP_W], opt_d_i[KEEP_W-2:SEL_W]};
      end else begin : g_nohi
         assign unused_opt_bits = 1'b0;
      end
   endgenerate

   assign wd_clr  = clr_wd_i | sleep_i;
   assign pre_evt = (route_q == ROUTE_WATCHDOG) ? base_ovf : tmr_src_i;
   assign pre_clr = opt_we_i | (wd_clr & (route_q == ROUTE_WATCHDOG));

   wdt_sp_base_cnt #(.CNT_W(BASE_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (cfg_wd_en_i),
      .tick_i (osc_tick_i),
      .clr_i  (wd_clr),
      .ovf_o  (base_ovf)
   );

   wdt_sp_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (pre_evt),
      .clr_i   (pre_clr),
      .route_i (route_q),
      .sel_i   (sel_q),
      .hit_o   (pre_hit)
   );

   assign timeout   = (route_q == ROUTE_WATCHDOG) ? pre_hit : base_ovf;
   assign tick_next = (route_q == ROUTE_WATCHDOG) ? tmr_src_i : pre_hit;

   wdt_sp_event_out u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .timeout_i    (timeout),
      .in_sleep_i   (in_sleep_i),
      .clr_wd_i     (clr_wd_i),
      .tmr_tick_i   (tick_next),
      .rst_pulse_o  (rst_pulse_o),
      .wake_pulse_o (wake_pulse_o),
      .to_n_o       (to_n_o),
      .tmr_tick_o   (tmr_tick_o)
   );

endmodule

// File: rtl/wdt_sp_checker.sv
module wdt_sp_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_wd_en_i,
   input logic clr_wd_i,
   input logic sleep_i,
   input logic tmr_src_i,
   input logic route_bit,
   input logic rst_pulse_o,
   input logic wake_pulse_o,
   input logic to_n_o,
   input logic tmr_tick_o
);

   assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_pulse_o && wake_pulse_o));

   assert_rst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse_o |=> !rst_pulse_o);

   assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse_o |=> !wake_pulse_o);

   assert_status_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_n_o) |-> (rst_pulse_o || wake_pulse_o));

   assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cfg_wd_en_i) |-> (!rst_pulse_o && !wake_pulse_o));

   assert_clear_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_wd_i) |-> to_n_o);

   assert_strobe_no_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_wd_i || sleep_i) |-> (!rst_pulse_o && !wake_pulse_o));

   assert_raw_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(route_bit) |-> (tmr_tick_o == $past(tmr_src_i)));

endmodule

bind wdt_shared_prescaler wdt_sp_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wd_en_i  (cfg_wd_en_i),
   .clr_wd_i     (clr_wd_i),
   .sleep_i      (sleep_i),
   .tmr_src_i    (tmr_src_i),
   .route_bit    (route_q),
   .rst_pulse_o  (rst_pulse_o),
   .wake_pulse_o (wake_pulse_o),
   .to_n_o       (to_n_o),
   .tmr_tick_o   (tmr_tick_o)
);

// File: tb/wdt_shared_prescaler_tb.sv
`timescale 1ns/1ps
module wdt_shared_prescaler_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick_i = 1'b0;
   logic       tmr_src_i = 1'b0;
   logic       cfg_wd_en_i = 1'b1;
   logic       opt_we_i = 1'b0;
   logic [7:0] opt_d_i = 8'h00;
   logic       clr_wd_i = 1'b0;
   logic       sleep_i = 1'b0;
   logic       in_sleep_i = 1'b0;
   logic       rst_pulse_o, wake_pulse_o, to_n_o, tmr_tick_o;

   int checks = 0;
   int errors = 0;
   int osc_div = 0;
   int tmr_div = 0;
   int cyc = 0;

   // reference model state
   int   m_wd, m_pre, m_opt;
   logic e_rst, e_wake, e_to, e_tick;

   always #5 clk = ~clk;

   wdt_shared_prescaler u_dut (
      .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i), .tmr_src_i(tmr_src_i),
      .cfg_wd_en_i(cfg_wd_en_i), .opt_we_i(opt_we_i), .opt_d_i(opt_d_i),
      .clr_wd_i(clr_wd_i), .sleep_i(sleep_i), .in_sleep_i(in_sleep_i),
      .rst_pulse_o(rst_pulse_o), .wake_pulse_o(wake_pulse_o),
      .to_n_o(to_n_o), .tmr_tick_o(tmr_tick_o));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // stimulus pattern generator for the two tick inputs
   always @(negedge clk) begin
      cyc++;
      osc_tick_i = (osc_div != 0) && (cyc % osc_div == 0);
      tmr_src_i  = (tmr_div != 0) && (cyc % tmr_div == 0);
   end

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wd = 0; m_pre = 0; m_opt = 255;
         e_rst = 0; e_wake = 0; e_to = 1; e_tick = 0;
      end else begin
         bit psa, clr, ovf, ev, hit, to;
         int ps, n;
         psa = m_opt[3];
         ps  = m_opt & 7;
         clr = clr_wd_i || sleep_i;
         ovf = 0;
         if (!cfg_wd_en_i || clr) m_wd = 0;
         else if (osc_tick_i) begin
            if (m_wd == 255) begin ovf = 1; m_wd = 0; end
            else m_wd = m_wd + 1;
         end
         ev  = psa ? ovf : tmr_src_i;
         hit = 0;
         if (opt_we_i || (clr && psa)) m_pre = 0;
         else if (ev) begin
            n = psa ? ps : ps + 1;
            if (m_pre % (1 << n) == (1 << n) - 1) hit = 1;
            m_pre = (m_pre + 1) % 256;
         end
         to = psa ? hit : ovf;
         e_rst  = to && !in_sleep_i;
         e_wake = to && in_sleep_i;
         e_tick = psa ? tmr_src_i : hit;
         if (clr_wd_i) e_to = 1;
         else if (to) e_to = 0;
         if (opt_we_i) m_opt = opt_d_i;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 reset pulse", rst_pulse_o, e_rst);
         chk("R4 wake pulse", wake_pulse_o, e_wake);
         chk("R5 status", to_n_o, e_to);
         chk(m_opt[3] ? "R9 raw tick" : "R10 divided tick", tmr_tick_o, e_tick);
      end
   end

   task automatic tally(input int n, output int r, output int w, output int t);
      r = 0; w = 0; t = 0;
      repeat (n) begin
         @(negedge clk); #1;
         r += rst_pulse_o; w += wake_pulse_o; t += tmr_tick_o;
      end
   endtask

   task automatic wr_opt(input logic [7:0] v);
      @(negedge clk); opt_we_i = 1; opt_d_i = v;
      @(negedge clk); opt_we_i = 0;
   endtask

   task automatic strobe_clr();
      @(negedge clk); clr_wd_i = 1;
      @(negedge clk); clr_wd_i = 0;
   endtask

   task automatic strobe_sleep();
      @(negedge clk); sleep_i = 1;
      @(negedge clk); sleep_i = 0;
   endtask

   initial begin
      int r, w, t;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R1: reset state
      chk("R1 to_n after reset", to_n_o, 1);
      chk("R1 rst after reset", rst_pulse_o, 0);
      chk("R1 wake after reset", wake_pulse_o, 0);
      chk("R1 tick after reset", tmr_tick_o, 0);
      // R1/R9: default tap 7 postscaled: one time-out in 32768 ticks
      osc_div = 1;
      tally(32700, r, w, t);
      chk("R1 no early timeout", r, 0);
      tally(200, r, w, t);
      chk("R1 default timeout count", r, 1);
      chk("R5 status low after timeout", to_n_o, 0);
      // R2: routed to timer, every overflow times out
      strobe_clr();
      chk("R7 status set by clear", to_n_o, 1);
      wr_opt(8'h00);
      osc_div = 2;
      tally(1100, r, w, t);
      chk("R2 overflow timeouts", r, 2);
      chk("R3 no wake while awake", w, 0);
      // R4: in sleep, postscaled by 2
      in_sleep_i = 1; osc_div = 1;
      strobe_clr();
      wr_opt(8'h09);
      tally(1100, r, w, t);
      chk("R4 wake count", w, 2);
      chk("R4 no reset in sleep", r, 0);
      // R8: sleep strobe leaves status, restarts count
      strobe_sleep();
      chk("R8 status unchanged by sleep strobe", to_n_o, 0);
      tally(500, r, w, t);
      chk("R8 restart after sleep strobe", w, 0);
      in_sleep_i = 0;
      // R7: clear also restarts the postscaler (tap 1, 512 ticks)
      strobe_clr();
      tally(400, r, w, t);
      strobe_clr();
      tally(400, r, w, t);
      chk("R7 postscaler cleared", r, 0);
      // R6: disabled watchdog never times out
      wr_opt(8'h08);
      cfg_wd_en_i = 0;
      tally(2000, r, w, t);
      chk("R6 disabled no pulses", r + w, 0);
      cfg_wd_en_i = 1;
      // R10: divide by 16, clear strobes do not disturb it
      osc_div = 0; tmr_div = 1;
      wr_opt(8'h03);
      tally(80, r, w, t);
      strobe_clr();
      tally(78, r, w, t);
      chk("R10 tick count with clears", t, 5);
      // R11: option write restarts prescaler (divide by 8)
      wr_opt(8'h02);
      repeat (2) @(negedge clk);
      opt_we_i = 1; opt_d_i = 8'h02;
      @(negedge clk); opt_we_i = 0;
      tally(12, r, w, t);
      chk("R11 restart on write", t, 1);
      // R9: raw timer ticks with irregular source
      tmr_div = 3;
      wr_opt(8'h0A);
      tally(60, r, w, t);
      chk("R9 raw tick count", t, 20);
      tmr_div = 0;
      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1..run hung actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule